// File: doc/BRIEF.md
# Checkstop and Debug State Controller

This block holds the halted-on-error condition of a processor core and decides how that condition coexists with debug sessions. A machine check that arrives while machine checks are disabled stops the core for good. From then on only a reset brings back normal execution. A debugger can still reach the stopped core. A debug request raises a wakeup line so that the clock can be restored. Once the clock is reported available, the core enters a debug session and the stop indication is hidden for the length of that session. When the session closes, the core drops back into the stopped condition and does not run.

A debug request while running opens an ordinary session, and closing it returns to running. During either kind of session, a debug control request can raise a reset-out line for a fixed number of cycles. The outputs follow the registered state, so each one changes in the cycle after the inputs that cause it are sampled.

Top module: `chkstop_dbg_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the block returns to running, and all four outputs are 0 after that edge.
- R2: In the running state, `mchk_evt_i`=1 with `mchk_en_i`=0 enters checkstop. With `mchk_en_i`=1 the event has no effect and the block stays running.
- R3: `chkstop_o` is 1 exactly while the block is in checkstop, including while it waits for the clock after a wakeup. It is 0 in every other state.
- R4: In checkstop, `dbg_req_i`=1 raises `wake_o` from the next cycle on. `wake_o` then stays 1 until the clock is reported available.
- R5: While `wake_o` is 1, `clk_ok_i`=1 enters a debug session. In the next cycle `dbg_active_o`=1, `wake_o`=0 and `chkstop_o`=0.
- R6: `dbg_done_i`=1 in a session that began from checkstop returns to checkstop (`chkstop_o`=1, `dbg_active_o`=0). The block does not return to running.
- R7: In checkstop, `dbg_done_i`, `mchk_evt_i` and `clk_ok_i` have no effect. Only a reset or a debug request leaves the state.
- R8: In the running state, `dbg_req_i`=1 opens a session (`dbg_active_o`=1, `chkstop_o`=0). `dbg_done_i`=1 in that session returns to running, with all outputs 0.
- R9: `rso_req_i`=1 sampled during a debug session drives `reset_out_o` to 1 for exactly `RSTOUT_CYCLES` cycles (default 4), starting the next cycle. A new request reloads the count.
- R10: `rso_req_i` sampled outside a debug session has no effect on `reset_out_o`.
- R11: In the running state, a qualifying machine check takes priority over a debug request that is sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mchk_evt_i | input | 1 | Machine check event |
| mchk_en_i | input | 1 | Machine-check-enable bit |
| dbg_req_i | input | 1 | Debug request |
| clk_ok_i | input | 1 | Clock available to the core |
| dbg_done_i | input | 1 | Debug session exit |
| rso_req_i | input | 1 | Debug control request for reset-out |
| chkstop_o | output | 1 | Checkstop status |
| wake_o | output | 1 | Wakeup request |
| dbg_active_o | output | 1 | Debug session active |
| reset_out_o | output | 1 | Reset-out request |

## Verification
The hardest case to reach from the ports is a session that began from checkstop and then ends. Reaching it takes a disabled machine check, a debug request, the clock arriving and an exit, in that order. A reset-out request during the session adds to that sequence. Directed steps walk this path exactly, including extra exit and machine-check pulses applied while stopped. Biased random stimulus then keeps resets rare and debug requests frequent, so that the stopped-debug-stopped loop recurs many times, and a bench model checks every output on every cycle.

// File: rtl/cs_pkg.sv
// Package: shared state encoding for the checkstop/debug controller.
// Assumes: one-hot-free binary encoding; decode lives in csd_outdec.
package cs_pkg;
    typedef enum logic [2:0] {
        CS_RUN      = 3'd0,
        CS_STOP     = 3'd1,
        CS_WAKE     = 3'd2,
        CS_DBG_STOP = 3'd3,
        CS_DBG_RUN  = 3'd4
    } cs_state_t;
endpackage

// File: rtl/csd_next.sv
// Module: next-state logic of the checkstop/debug controller.
// Assumes: inputs are synchronous to the state register's clock.
module csd_next
    import cs_pkg::*;
(
    input  cs_state_t cur_i,
    input  logic      mchk_evt_i,
    input  logic      mchk_en_i,
    input  logic      dbg_req_i,
    input  logic      clk_ok_i,
    input  logic      dbg_done_i,
    output cs_state_t nxt_o
);
    // Transition rules; checkstop entry outranks a debug request.
    always_comb begin
        nxt_o = cur_i;
        case (cur_i)
            CS_RUN: begin
                if (mchk_evt_i && !mchk_en_i) nxt_o = CS_STOP;
                else if (dbg_req_i)           nxt_o = CS_DBG_RUN;
            end
            CS_STOP:     if (dbg_req_i)  nxt_o = CS_WAKE;
            CS_WAKE:     if (clk_ok_i)   nxt_o = CS_DBG_STOP;
            CS_DBG_STOP: if (dbg_done_i) nxt_o = CS_STOP;
            CS_DBG_RUN:  if (dbg_done_i) nxt_o = CS_RUN;
            default:                     nxt_o = CS_RUN;
        endcase
    end
endmodule

// File: rtl/csd_outdec.sv
// Module: decodes the registered state into the status outputs.
// Assumes: state comes straight from a flop, so outputs are glitch-limited.
module csd_outdec
    import cs_pkg::*;
(
    input  cs_state_t st_i,
    output logic      stop_o,
    output logic      wake_o,
    output logic      dbg_o
);
    // Moore decode; stop flag is hidden during any debug session.
    always_comb begin
        stop_o = (st_i == CS_STOP) || (st_i == CS_WAKE);
        wake_o = (st_i == CS_WAKE);
        dbg_o  = (st_i == CS_DBG_STOP) || (st_i == CS_DBG_RUN);
    end
endmodule

// File: rtl/csd_rstout.sv
// Module: stretches a reset-out request into a fixed-length pulse.
// Assumes: req_i is already qualified by the debug-session condition.
module csd_rstout #(
    parameter int PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic rso_o
);
    generate
        if (PULSE == 1) begin : g_single
            logic q;
            // Single-cycle variant: one flop follows the request.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= req_i;
            end
            assign rso_o = q;
        end else begin : g_count
            localparam int CW = $clog2(PULSE + 1);
            logic [CW-1:0] cnt_q;
            // Down-counter reloaded on each request.
            always_ff @(posedge clk) begin
                if (!rst_n)              cnt_q <= '0;
                else if (req_i)          cnt_q <= CW'(PULSE);
                else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            end
            assign rso_o = (cnt_q != '0);
        end
    endgenerate
endmodule

// File: rtl/chkstop_dbg_ctrl.sv
// Module: top of the checkstop/debug controller. Holds the state register,
// the reset-out pulse stretcher and the output decode.
// Assumes: synchronous active-low reset; clock availability is a plain input.
module chkstop_dbg_ctrl
    import cs_pkg::*;
#(
    parameter int RSTOUT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mchk_evt_i,
    input  logic mchk_en_i,
    input  logic dbg_req_i,
    input  logic clk_ok_i,
    input  logic dbg_done_i,
    input  logic rso_req_i,
    output logic chkstop_o,
    output logic wake_o,
    output logic dbg_active_o,
    output logic reset_out_o
);
    cs_state_t state_q;
    cs_state_t state_d;
    logic      in_dbg;

    csd_next u_next (
        .cur_i      (state_q),
        .mchk_evt_i (mchk_evt_i),
        .mchk_en_i  (mchk_en_i),
        .dbg_req_i  (dbg_req_i),
        .clk_ok_i   (clk_ok_i),
        .dbg_done_i (dbg_done_i),
        .nxt_o      (state_d)
    );

    // State register; reset forces the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    csd_outdec u_dec (
        .st_i   (state_q),
        .stop_o (chkstop_o),
        .wake_o (wake_o),
        .dbg_o  (in_dbg)
    );

    assign dbg_active_o = in_dbg;

    csd_rstout #(.PULSE(RSTOUT_CYCLES)) u_rso (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (in_dbg && rso_req_i),
        .rso_o (reset_out_o)
    );
endmodule

// File: rtl/chkstop_dbg_ctrl_chk.sv
// Checker: temporal properties of chkstop_dbg_ctrl, bound to every instance.
module chkstop_dbg_ctrl_chk
    import cs_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input cs_state_t st,
    input logic      mchk_evt_i,
    input logic      mchk_en_i,
    input logic      dbg_req_i,
    input logic      clk_ok_i,
    input logic      dbg_done_i,
    input logic      rso_req_i,
    input logic      chkstop_o,
    input logic      wake_o,
    input logic      dbg_active_o,
    input logic      reset_out_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!chkstop_o && !wake_o && !dbg_active_o && !reset_out_o));

    assert_enter_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_RUN && mchk_evt_i && !mchk_en_i) |=> chkstop_o);

    assert_stop_hidden_in_dbg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(chkstop_o && dbg_active_o));

    assert_wake_on_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_STOP && dbg_req_i) |=> wake_o);

    assert_clock_enters_dbg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && clk_ok_i) |=> (dbg_active_o && !wake_o && !chkstop_o));

    assert_exit_back_to_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_DBG_STOP && dbg_done_i) |=> (chkstop_o && !dbg_active_o));

    assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (chkstop_o && !wake_o && !dbg_req_i) |=> (chkstop_o && !wake_o));

    assert_rso_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_out_o) |-> $past(dbg_active_o && rso_req_i));

    assert_mchk_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CS_RUN && mchk_evt_i && !mchk_en_i && dbg_req_i) |=> !dbg_active_o);
endmodule

bind chkstop_dbg_ctrl chkstop_dbg_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (state_q),
    .mchk_evt_i   (mchk_evt_i),
    .mchk_en_i    (mchk_en_i),
    .dbg_req_i    (dbg_req_i),
    .clk_ok_i     (clk_ok_i),
    .dbg_done_i   (dbg_done_i),
    .rso_req_i    (rso_req_i),
    .chkstop_o    (chkstop_o),
    .wake_o       (wake_o),
    .dbg_active_o (dbg_active_o),
    .reset_out_o  (reset_out_o)
);

// File: tb/sim_chkstop_dbg_ctrl.sv
`timescale 1ns/1ps
module sim_chkstop_dbg_ctrl;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mchk = 1'b0, men = 1'b0, dreq = 1'b0, cok = 1'b0, done = 1'b0, rreq = 1'b0;
    logic chk, wk, dbg, rso;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    // Bench model: 0 run, 1 stop, 2 wake, 3 debug-from-stop, 4 debug-from-run.
    int ms = 0;
    int cnt = 0;

    always #5 clk = ~clk;

    chkstop_dbg_ctrl #(.RSTOUT_CYCLES(P)) u0 (
        .clk(clk), .rst_n(rst_n), .mchk_evt_i(mchk), .mchk_en_i(men),
        .dbg_req_i(dreq), .clk_ok_i(cok), .dbg_done_i(done), .rso_req_i(rreq),
        .chkstop_o(chk), .wake_o(wk), .dbg_active_o(dbg), .reset_out_o(rso)
    );

    function automatic int next_ms(int s, bit m, bit e, bit d, bit c, bit x);
        case (s)
            0: return (m && !e) ? 1 : (d ? 4 : 0);
            1: return d ? 2 : 1;
            2: return c ? 3 : 2;
            3: return x ? 1 : 3;
            default: return x ? 0 : 4;
        endcase
    endfunction

    function automatic bit in_debug(int s);
        return (s == 3) || (s == 4);
    endfunction

    task automatic cmp(logic act, bit exp, string what, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Apply inputs now (at a falling edge), advance model at rising edge, check at next falling edge.
    task automatic step(bit r, bit m, bit e, bit d, bit c, bit x, bit q, string tag);
        rst_n = r; mchk = m; men = e; dreq = d; cok = c; done = x; rreq = q;
        @(posedge clk);
        if (!r) begin
            ms = 0; cnt = 0;
        end else begin
            if (in_debug(ms) && q) cnt = P;
            else if (cnt > 0) cnt--;
            ms = next_ms(ms, m, e, d, c, x);
        end
        @(negedge clk);
        cmp(chk, (ms == 1) || (ms == 2), "chkstop", tag);
        cmp(wk,  (ms == 2),              "wake",    tag);
        cmp(dbg, in_debug(ms),           "dbg",     tag);
        cmp(rso, (cnt != 0),             "rstout",  tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(0,0,0,0,0,0,0, "R1");
        step(0,1,0,1,1,1,1, "R1");
        // R2: enabled machine check is ignored
        step(1,1,1,0,0,0,0, "R2");
        step(1,0,0,0,0,0,1, "R10");
        // R2/R3: disabled machine check stops
        step(1,1,0,0,0,0,0, "R2");
        step(1,0,0,0,0,0,0, "R3");
        // R7: stop is sticky
        step(1,1,0,0,1,1,1, "R7");
        step(1,0,0,0,1,1,0, "R7");
        // R4: wakeup held until clock
        step(1,0,0,1,0,0,0, "R4");
        step(1,0,0,0,0,1,0, "R4");
        // R5: clock enters debug
        step(1,0,0,0,1,0,0, "R5");
        // R9: reset-out pulse and reload
        step(1,0,0,0,0,0,1, "R9");
        step(1,0,0,0,0,0,0, "R9");
        step(1,0,0,0,0,0,1, "R9");
        for (int i = 0; i < P + 1; i++) step(1,0,0,0,0,0,0, "R9");
        // R6: exit returns to stop
        step(1,0,0,0,0,1,0, "R6");
        step(1,0,0,0,0,0,1, "R10");
        step(1,0,0,0,0,0,0, "R10");
        // R1: reset leaves stop
        step(0,0,0,0,0,0,0, "R1");
        // R8: debug from running
        step(1,0,0,1,0,0,0, "R8");
        step(1,1,0,0,0,0,0, "R8");
        step(1,0,0,0,0,1,0, "R8");
        // R11: machine check beats debug request
        step(1,1,0,1,0,0,0, "R11");
        step(0,0,0,0,0,0,0, "R1");
        // Random phase, biased towards debug traffic
        for (int i = 0; i < 5000; i++) begin
            step(($urandom % 200) != 0,
                 ($urandom % 8) == 0, ($urandom % 2) == 0,
                 ($urandom % 4) == 0, ($urandom % 3) == 0,
                 ($urandom % 6) == 0, ($urandom % 10) == 0, "R3-R9 random");
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule